// File: doc/BRIEF.md
# Low-Power State Sequencer

This block sits beside a small processor core and decides when the core sleeps and when it wakes. Instruction decode raises a light-sleep or deep-sleep request. In light sleep, the core clock is gated while the oscillator and the peripherals keep running. In deep sleep, the oscillator is switched off and the peripherals receive a power-down level. The block qualifies every interrupt source with its own enable flag before that source may wake the core. One external source is wired so that it can never wake the core. A qualifying request that is already pending when a sleep request arrives cancels the sleep at once.

After a reset, and after any wake from deep sleep, the oscillator needs time to settle. The block holds the core clock off for 2^STAB_BITS oscillator cycles and then releases it with a one-cycle resume pulse. When an interrupt wakes the core and the master enable is set, the block waits for a fixed number of retired instructions before it grants the vectored interrupt. The keyboard and watch-timer sources never receive that grant.

All pins are plain control levels or pulses. No pin carries a data stream, so no pin has back-pressure.

Top module: `sleep_ctl`

## Requirements
- R1: While `rst_n` is low, in any state, `cpu_clk_en`=0, `osc_en`=1, `periph_pd`=0, `resume`=0 and `vec_permit`=0, and the block is in warm-up.
- R2: After reset is released, `cpu_clk_en` stays 0 for exactly 2^STAB_BITS clock edges. It is 1 after the last of them, and `resume` pulses for one cycle at that point.
- R3: While in light sleep (entered by `idle_req`), `cpu_clk_en`=0, `osc_en`=1 and `periph_pd`=0.
- R4: While in deep sleep (entered by `stop_req`), `osc_en`=0, `periph_pd`=1 and `cpu_clk_en`=0.
- R5: A source i wakes the core only when `irq_pend[i]` and `irq_en[i]` are both 1. Bit EXT0_IDX (default 0) never wakes the core. A wake from light sleep sets `cpu_clk_en`=1 and pulses `resume` at the next edge.
- R6: If a wake condition from R5 holds in the same cycle that a sleep request is sampled in run, the core stays in run, `resume` pulses, and the oscillator stays on.
- R7: After an interrupt wake with `ime`=0, `vec_permit` never pulses, however many instructions retire.
- R8: After an interrupt wake with `ime`=1, `vec_permit` pulses for one cycle. The pulse comes after the edge that samples the DEFER_INSNS-th (default 2) `retire` while the core clock is on. `retire` pulses seen while the clock is gated are not counted.
- R9: If the only waking sources are KEY_IDX (default 4) or WT_IDX (default 5), `vec_permit` never pulses, even with `ime`=1.
- R10: A wake from deep sleep first turns the oscillator on with `cpu_clk_en` still 0. A full 2^STAB_BITS warm-up follows, and then the `resume` pulse.
- R11: A `stop_req` sampled in light sleep, with no wake condition, moves the block to deep sleep.
- R12: Reset discards a vector grant that is pending, including any retires already counted toward it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_req | input | 1 | Light-sleep request from decode |
| stop_req | input | 1 | Deep-sleep request from decode (takes priority) |
| irq_pend | input | N_SRC | Per-source interrupt request flags |
| irq_en | input | N_SRC | Per-source interrupt enable flags |
| ime | input | 1 | Interrupt master enable |
| retire | input | 1 | One instruction retired this cycle |
| cpu_clk_en | output | 1 | Core clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| periph_pd | output | 1 | Peripheral power-down level |
| resume | output | 1 | One-cycle pulse when the core clock restarts |
| vec_permit | output | 1 | One-cycle grant for the vectored interrupt |

## Verification
The bench targets four failure modes:
- **Excluded source.** It raises the excluded source, and an unenabled request, during light sleep. A design that ORed the raw flags would wake early.
- **Warm-up length.** It measures the warm-up edge by edge, both after reset and after deep sleep. An off-by-one counter, or a wake from deep sleep that skips warm-up, moves the first clock-on cycle.
- **Retire counting.** It pulses `retire` while the clock is gated and counts the retires needed for the grant exactly. It also asserts reset midway through the count. A grant that counted gated retires, fired one instruction early, or survived reset would show up as an unexpected or missing pulse on the event scoreboard.
- **Sleep abort and no-vector sources.** It covers a sleep request that coincides with a pending request, and wakes by the keyboard and watch-timer sources with `ime` set. These catch a design that sleeps anyway or grants a vector that should never come.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_STOP = 2'd2,
    PM_WARM = 2'd3
  } pm_state_e;
endpackage

// File: rtl/wake_qual.sv
module wake_qual #(
  parameter int N_SRC    = 6,
  parameter int EXT0_IDX = 0,
  parameter int KEY_IDX  = 4,
  parameter int WT_IDX   = 5
) (
  input  logic [N_SRC-1:0] irq_pend,
  input  logic [N_SRC-1:0] irq_en,
  output logic             wake_hit,
  output logic             vec_src
);
  localparam logic [N_SRC-1:0] ONE_HOT  = N_SRC'(1);
  localparam logic [N_SRC-1:0] WAKE_MSK = ~(ONE_HOT << EXT0_IDX);
  localparam logic [N_SRC-1:0] VEC_MSK  = WAKE_MSK & ~(ONE_HOT << KEY_IDX) & ~(ONE_HOT << WT_IDX);

  logic [N_SRC-1:0] live;

  // a source counts only with its own enable flag set
  assign live     = irq_pend & irq_en;
  assign wake_hit = |(live & WAKE_MSK);
  assign vec_src  = |(live & VEC_MSK);
endmodule

// File: rtl/warm_timer.sv
module warm_timer #(
  parameter int STAB_BITS = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  logic [STAB_BITS-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
    else          cnt <= '0;
  end

  // terminal count reached on the last cycle of the window
  assign done = run & (&cnt);
endmodule

// File: rtl/vec_defer.sv
module vec_defer #(
  parameter int DEFER_INSNS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_load,
  input  logic arm_val,
  input  logic clk_on,
  input  logic retire,
  output logic permit
);
  localparam int CW = $clog2(DEFER_INSNS + 1);
  localparam logic [CW-1:0] LAST = CW'(DEFER_INSNS - 1);

  logic          armed;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      cnt    <= '0;
      permit <= 1'b0;
    end else if (arm_load) begin
      armed  <= arm_val;
      cnt    <= '0;
      permit <= 1'b0;
    end else if (armed && clk_on && retire) begin
      if (cnt == LAST) begin
        armed  <= 1'b0;
        cnt    <= '0;
        permit <= 1'b1;
      end else begin
        cnt    <= cnt + 1'b1;
        permit <= 1'b0;
      end
    end else begin
      permit <= 1'b0;
    end
  end
endmodule

// File: rtl/sleep_ctl.sv
module sleep_ctl #(
  parameter int N_SRC       = 6,
  parameter int EXT0_IDX    = 0,
  parameter int KEY_IDX     = 4,
  parameter int WT_IDX      = 5,
  parameter int STAB_BITS   = 17,
  parameter int DEFER_INSNS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_req,
  input  logic             stop_req,
  input  logic [N_SRC-1:0] irq_pend,
  input  logic [N_SRC-1:0] irq_en,
  input  logic             ime,
  input  logic             retire,
  output logic             cpu_clk_en,
  output logic             osc_en,
  output logic             periph_pd,
  output logic             resume,
  output logic             vec_permit
);
  import sleep_pkg::*;

  pm_state_e st, st_nxt;
  logic wake_hit, vec_src, warm_done;
  logic resume_d, arm_load, arm_val;

  wake_qual #(
    .N_SRC(N_SRC), .EXT0_IDX(EXT0_IDX), .KEY_IDX(KEY_IDX), .WT_IDX(WT_IDX)
  ) u_qual (
    .irq_pend(irq_pend), .irq_en(irq_en),
    .wake_hit(wake_hit), .vec_src(vec_src)
  );

  warm_timer #(.STAB_BITS(STAB_BITS)) u_warm (
    .clk(clk), .rst_n(rst_n), .run(st == PM_WARM), .done(warm_done)
  );

  vec_defer #(.DEFER_INSNS(DEFER_INSNS)) u_defer (
    .clk(clk), .rst_n(rst_n), .arm_load(arm_load), .arm_val(arm_val),
    .clk_on(cpu_clk_en), .retire(retire), .permit(vec_permit)
  );

  always_comb begin
    st_nxt   = st;
    resume_d = 1'b0;
    arm_load = 1'b0;
    arm_val  = ime & vec_src;
    unique case (st)
      PM_RUN: begin
        if (stop_req || idle_req) begin
          if (wake_hit) begin
            resume_d = 1'b1;
            arm_load = 1'b1;
          end else begin
            st_nxt = stop_req ? PM_STOP : PM_IDLE;
          end
        end
      end
      PM_IDLE: begin
        if (wake_hit) begin
          st_nxt   = PM_RUN;
          resume_d = 1'b1;
          arm_load = 1'b1;
        end else if (stop_req) begin
          st_nxt = PM_STOP;
        end
      end
      PM_STOP: begin
        if (wake_hit) begin
          st_nxt   = PM_WARM;
          arm_load = 1'b1;
        end
      end
      PM_WARM: begin
        if (warm_done) begin
          st_nxt   = PM_RUN;
          resume_d = 1'b1;
        end
      end
      default: st_nxt = PM_WARM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= PM_WARM;
      resume <= 1'b0;
    end else begin
      st     <= st_nxt;
      resume <= resume_d;
    end
  end

  assign cpu_clk_en = (st == PM_RUN);
  assign osc_en     = (st != PM_STOP);
  assign periph_pd  = (st == PM_STOP);
endmodule

// File: rtl/sleep_ctl_chk.sv
module sleep_ctl_chk (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cpu_clk_en,
  input logic                 osc_en,
  input logic                 periph_pd,
  input logic                 resume,
  input logic                 vec_permit,
  input sleep_pkg::pm_state_e st,
  input logic                 wake_hit
);
  import sleep_pkg::*;

  // R4
  stop_holds_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PM_STOP && !wake_hit) |=> (periph_pd && !osc_en));

  // R5
  idle_stays_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PM_IDLE && !wake_hit) |=> !cpu_clk_en);

  // R6
  resume_with_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> cpu_clk_en);

  // R8
  permit_after_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_permit |-> $past(cpu_clk_en));

  // R10
  stop_wake_warms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PM_STOP && wake_hit) |=> (osc_en && !cpu_clk_en && !resume));
endmodule

bind sleep_ctl sleep_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
  .periph_pd(periph_pd), .resume(resume), .vec_permit(vec_permit),
  .st(st), .wake_hit(wake_hit)
);

// File: tb/sleep_ctl_bench.sv
module sleep_ctl_bench;
  localparam int N  = 6;
  localparam int SB = 4;
  localparam int WARM = 1 << SB;

  typedef struct {
    byte   kind;
    string req;
  } evt_t;

  logic clk = 1'b0;
  logic rst_n, idle_req, stop_req, ime, retire;
  logic [N-1:0] irq_pend, irq_en;
  logic cpu_clk_en, osc_en, periph_pd, resume, vec_permit;

  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;
  evt_t exp_q[$];

  always #10 clk = ~clk;

  sleep_ctl #(.N_SRC(N), .STAB_BITS(SB)) u_sleep_ctl (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .stop_req(stop_req),
    .irq_pend(irq_pend), .irq_en(irq_en), .ime(ime), .retire(retire),
    .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .periph_pd(periph_pd),
    .resume(resume), .vec_permit(vec_permit)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_evt(input byte k, input string req);
    evt_t e;
    e.kind = k;
    e.req  = req;
    exp_q.push_back(e);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // monitor: every pulse must match the head of the scoreboard queue
  always @(negedge clk) begin
    if (!done) begin
      if (resume === 1'b1) begin
        n_chk++;
        if (exp_q.size() == 0 || exp_q[0].kind != "R") begin
          n_err++;
          $display("FAIL %s resume pulse: actual=R expected=%s",
                   exp_q.size() ? exp_q[0].req : "R6",
                   exp_q.size() ? string'(exp_q[0].kind) : "none");
        end else void'(exp_q.pop_front());
      end
      if (vec_permit === 1'b1) begin
        n_chk++;
        if (exp_q.size() == 0 || exp_q[0].kind != "V") begin
          n_err++;
          $display("FAIL %s vec_permit pulse: actual=V expected=%s",
                   exp_q.size() ? exp_q[0].req : "R7",
                   exp_q.size() ? string'(exp_q[0].kind) : "none");
        end else void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=hung expected=finished");
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; idle_req = 1'b0; stop_req = 1'b0; ime = 1'b0; retire = 1'b0;
    irq_pend = '0; irq_en = '0;
    step(2);
    // R1 reset levels
    chk("R1", "cpu_clk_en", cpu_clk_en, 1'b0);
    chk("R1", "osc_en", osc_en, 1'b1);
    chk("R1", "periph_pd", periph_pd, 1'b0);
    chk("R1", "resume", resume, 1'b0);
    chk("R1", "vec_permit", vec_permit, 1'b0);
    // R2 warm-up length
    expect_evt("R", "R2");
    rst_n = 1'b1;
    step(WARM - 1);
    chk("R2", "cpu_clk_en last warm cycle", cpu_clk_en, 1'b0);
    step(1);
    chk("R2", "cpu_clk_en after warm-up", cpu_clk_en, 1'b1);

    // R3 light sleep, R5 qualification, R7 no vector with ime=0
    idle_req = 1'b1; step(1); idle_req = 1'b0;
    chk("R3", "cpu_clk_en", cpu_clk_en, 1'b0);
    chk("R3", "osc_en", osc_en, 1'b1);
    chk("R3", "periph_pd", periph_pd, 1'b0);
    irq_pend = 6'b000001; irq_en = 6'b000001; step(3);
    chk("R5", "excluded source woke core", cpu_clk_en, 1'b0);
    irq_pend = 6'b000100; irq_en = 6'b000000; step(3);
    chk("R5", "unenabled source woke core", cpu_clk_en, 1'b0);
    expect_evt("R", "R5");
    irq_en = 6'b000100; step(1);
    chk("R5", "enabled source wake", cpu_clk_en, 1'b1);
    irq_pend = '0; irq_en = '0;
    retire = 1'b1; step(3); retire = 1'b0; step(1);
    chk("R7", "vec_permit with ime=0", vec_permit, 1'b0);

    // R8 deferred vector from light sleep
    ime = 1'b1;
    idle_req = 1'b1; step(1); idle_req = 1'b0;
    retire = 1'b1; step(2); retire = 1'b0;
    irq_pend = 6'b000100; irq_en = 6'b000100;
    expect_evt("R", "R8");
    step(1);
    chk("R8", "wake with ime=1", cpu_clk_en, 1'b1);
    irq_pend = '0; irq_en = '0;
    retire = 1'b1; step(1);
    chk("R8", "permit after one retire", vec_permit, 1'b0);
    expect_evt("V", "R8");
    step(1); retire = 1'b0;
    chk("R8", "permit after two retires", vec_permit, 1'b1);
    step(1);
    chk("R8", "permit is one cycle", vec_permit, 1'b0);

    // R9 key and watch sources never vector
    for (int s = 4; s <= 5; s++) begin
      idle_req = 1'b1; step(1); idle_req = 1'b0;
      irq_pend = N'(1) << s; irq_en = N'(1) << s;
      expect_evt("R", "R9");
      step(1);
      chk("R9", "key/watch wake", cpu_clk_en, 1'b1);
      irq_pend = '0; irq_en = '0;
      retire = 1'b1; step(4); retire = 1'b0; step(1);
      chk("R9", "no permit for key/watch", vec_permit, 1'b0);
    end

    // R6 sleep aborted by pending request
    ime = 1'b0;
    irq_pend = 6'b001000; irq_en = 6'b001000;
    idle_req = 1'b1; expect_evt("R", "R6"); step(1); idle_req = 1'b0;
    chk("R6", "idle aborted", cpu_clk_en, 1'b1);
    stop_req = 1'b1; expect_evt("R", "R6"); step(1); stop_req = 1'b0;
    chk("R6", "stop aborted osc_en", osc_en, 1'b1);
    chk("R6", "stop aborted cpu_clk_en", cpu_clk_en, 1'b1);
    irq_pend = '0; irq_en = '0;

    // R4 deep sleep, R10 warm-up on exit, R8 gated retires ignored
    ime = 1'b1;
    stop_req = 1'b1; step(1); stop_req = 1'b0;
    chk("R4", "osc_en", osc_en, 1'b0);
    chk("R4", "periph_pd", periph_pd, 1'b1);
    chk("R4", "cpu_clk_en", cpu_clk_en, 1'b0);
    step(2);
    irq_pend = 6'b000010; irq_en = 6'b000010; step(1);
    irq_pend = '0; irq_en = '0;
    chk("R10", "osc_en on wake", osc_en, 1'b1);
    chk("R10", "periph_pd on wake", periph_pd, 1'b0);
    chk("R10", "cpu_clk_en on wake", cpu_clk_en, 1'b0);
    retire = 1'b1; step(WARM - 2); retire = 1'b0; step(1);
    chk("R10", "cpu_clk_en last warm cycle", cpu_clk_en, 1'b0);
    expect_evt("R", "R10");
    step(1);
    chk("R10", "cpu_clk_en after warm-up", cpu_clk_en, 1'b1);
    retire = 1'b1; step(1);
    chk("R8", "gated retires not counted", vec_permit, 1'b0);
    expect_evt("V", "R8");
    step(1); retire = 1'b0;
    chk("R8", "permit after stop wake", vec_permit, 1'b1);

    // R11 light sleep to deep sleep
    idle_req = 1'b1; step(1); idle_req = 1'b0;
    stop_req = 1'b1; step(1); stop_req = 1'b0;
    chk("R11", "osc_en", osc_en, 1'b0);
    chk("R11", "periph_pd", periph_pd, 1'b1);

    // R1 reset from deep sleep
    rst_n = 1'b0; step(1);
    chk("R1", "osc_en in reset from stop", osc_en, 1'b1);
    chk("R1", "periph_pd in reset from stop", periph_pd, 1'b0);
    expect_evt("R", "R2");
    rst_n = 1'b1; step(WARM);
    chk("R2", "cpu_clk_en after second warm-up", cpu_clk_en, 1'b1);

    // R12 reset drops a pending grant
    idle_req = 1'b1; step(1); idle_req = 1'b0;
    irq_pend = 6'b001000; irq_en = 6'b001000;
    expect_evt("R", "R12");
    step(1);
    irq_pend = '0; irq_en = '0;
    retire = 1'b1; step(1); retire = 1'b0;
    rst_n = 1'b0; step(2);
    expect_evt("R", "R12");
    rst_n = 1'b1; step(WARM);
    chk("R12", "cpu_clk_en after reset", cpu_clk_en, 1'b1);
    retire = 1'b1; step(4); retire = 1'b0; step(1);
    chk("R12", "no permit after reset", vec_permit, 1'b0);

    step(2);
    done = 1'b1;
    n_chk++;
    if (exp_q.size() != 0) begin
      n_err++;
      $display("FAIL %s missing pulse: actual=%0d pending expected=0", exp_q[0].req, exp_q.size());
    end
    report();
    $finish;
  end
endmodule